// File: doc/BRIEF.md
# Pipelined 32-Round Block Cipher Engine

This block encrypts or decrypts 128-bit data blocks at a rate of one block per clock. The 32 rounds of the cipher are unrolled into 32 registered stages. Every block carries a valid bit and an encrypt/decrypt flag with it through the stages. A new block may enter on any cycle. Its result leaves the last stage a fixed 32 cycles later, in the same order the blocks entered.

The 32-bit round keys are not derived inside the block. Software or a neighbouring unit writes them one at a time into a bank of 32 key registers through an index/data write port. Encryption and decryption run on the same stages. The only difference is which key each stage selects: stage i takes key i when encrypting and key 31−i when decrypting.

The stream input has a valid but no ready. There is no back-pressure in either direction: the engine accepts every block offered, and the consumer must take each result in the cycle out_valid is high. Key writes are allowed only while no block is in flight and in_valid is low.

Top module: `cipher_pipe`

## Requirements
- R1: An asynchronous active-low reset clears the valid bit of every stage, so out_valid is low during reset and stays low until a block presented after reset has had time to arrive. The round-key registers keep their contents through reset.
- R2: For every cycle in which in_valid is sampled high, out_valid is high exactly 32 cycles later. In every other cycle out_valid is low, so gaps in the input stream appear unchanged at the output.
- R3: The engine accepts a new block on every clock cycle. Results for back-to-back blocks leave on consecutive cycles, in input order.
- R4: With in_decrypt = 0, round r (r = 0..31) uses stored key r. Under the round keys derived from the 128-bit key 0123456789abcdeffedcba9876543210, the plaintext 0123456789abcdeffedcba9876543210 encrypts to 681edf34d206965e86b3e94f536e4246.
- R5: With in_decrypt = 1, round r uses stored key 31−r. Decryption is the exact inverse of encryption: decrypting 681edf34d206965e86b3e94f536e4246 under the R4 keys gives 0123456789abcdeffedcba9876543210, and decrypting any ciphertext gives back its plaintext.
- R6: The mode flag travels with its block. Adjacent blocks with different modes are each processed in their own mode.
- R7: When key_wr_en is high at a clock edge, key_wr_data is stored as key number key_wr_idx (0..31). Every block that enters after that edge uses the new value. Writes occur only while the pipeline is empty and in_valid is low.
- R8: Each round works as follows. Split the state into words X0..X3, with X0 the most significant. Pass each byte of X1^X2^X3^key through the cipher's fixed 8-bit substitution (examples: 00→D6, 01→90, FF→48). Mix the 32-bit result B as B^rotl(B,2)^rotl(B,10)^rotl(B,18)^rotl(B,24). Form the new state {X1,X2,X3,X0^mix}.
- R9: The output block is the state after the last round, with its four words in reverse order: the last-appended word goes to the most significant position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A block is presented this cycle |
| in_decrypt | input | 1 | 1 = decrypt, 0 = encrypt, for the presented block |
| in_block | input | 128 | Input data block |
| key_wr_en | input | 1 | Write strobe for the round-key bank |
| key_wr_idx | input | 5 | Round-key number to write |
| key_wr_data | input | 32 | Round-key value |
| out_valid | output | 1 | Result present this cycle |
| out_block | output | 128 | Result block |

## Verification
The engine is first checked against the published known answer in both directions. This pins down the substitution, the mixing rotations and the final word reversal, which a self-consistent model alone would not expose. Long back-to-back streams with randomly mixed modes separate per-block mode tracking from a single shared mode. Encrypting and then decrypting the same blocks separates a correctly reversed key order from a merely stable one. Sparse random valid patterns expose latency and gap errors. A reload of all keys, followed by a single-word key rewrite, exposes stale keys and indexing errors. A reset in the middle of a stream shows that blocks in flight are dropped while the keys are kept. All-zero keys with all-zero and all-one blocks drive the substitution with degenerate inputs.

// File: rtl/cipher_pkg.sv
package cipher_pkg;
  localparam int ROUNDS  = 32;
  localparam int WORD_W  = 32;
  localparam int BLOCK_W = 4 * WORD_W;
  localparam int KIDX_W  = $clog2(ROUNDS);

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [BLOCK_W-1:0] block_t;

  // multiplication in GF(2^8) modulo x^8+x^7+x^6+x^5+x^4+x^2+1
  function automatic logic [7:0] gf_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = sh[7] ? ({sh[6:0], 1'b0} ^ 8'hF5) : {sh[6:0], 1'b0};
    end
    return acc;
  endfunction

  // inverse by x^254 (0 maps to 0)
  function automatic logic [7:0] gf_inv(logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = x;
    acc = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  // circulant bit matrix, output bit i uses mask 0xA7 rotated left by i
  function automatic logic [7:0] bit_mix(logic [7:0] x);
    logic [7:0] m;
    logic [7:0] y;
    m = 8'hA7;
    for (int i = 0; i < 8; i++) begin
      y[i] = ^(x & m);
      m    = {m[6:0], m[7]};
    end
    return y;
  endfunction

  function automatic logic [7:0] subst_calc(logic [7:0] x);
    return bit_mix(gf_inv(bit_mix(x) ^ 8'hD3)) ^ 8'hD3;
  endfunction

  function automatic logic [255:0][7:0] subst_table();
    logic [255:0][7:0] t;
    for (int i = 0; i < 256; i++) t[i] = subst_calc(8'(i));
    return t;
  endfunction

  localparam logic [255:0][7:0] SUBST = subst_table();

  function automatic word_t rotl(word_t w, int n);
    return (w << n) | (w >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/cipher_round.sv
module cipher_round
  import cipher_pkg::*;
(
  input  block_t st_i,
  input  word_t  rk_i,
  output block_t st_o
);
  word_t w0, w1, w2, w3;
  word_t mixin;
  word_t sub;
  word_t lin;

  assign {w0, w1, w2, w3} = st_i;
  assign mixin = w1 ^ w2 ^ w3 ^ rk_i;

  for (genvar b = 0; b < 4; b++) begin : g_sub
    assign sub[8*b +: 8] = SUBST[mixin[8*b +: 8]];
  end

  assign lin  = sub ^ rotl(sub, 2) ^ rotl(sub, 10) ^ rotl(sub, 18) ^ rotl(sub, 24);
  assign st_o = {w1, w2, w3, w0 ^ lin};
endmodule

// File: rtl/pipe_stage.sv
module pipe_stage
  import cipher_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   vld_i,
  input  logic   dec_i,
  input  block_t blk_i,
  input  word_t  rk_i,
  output logic   vld_o,
  output logic   dec_o,
  output block_t blk_o
);
  block_t nxt;

  cipher_round u_round (
    .st_i (blk_i),
    .rk_i (rk_i),
    .st_o (nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= vld_i;
  end

  // data and mode are not reset; they load only with a valid block
  always_ff @(posedge clk) begin
    if (vld_i) begin
      dec_o <= dec_i;
      blk_o <= nxt;
    end
  end
endmodule

// File: rtl/round_key_bank.sv
module round_key_bank
  import cipher_pkg::*;
(
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [KIDX_W-1:0]            wr_idx,
  input  word_t                        wr_data,
  output logic [ROUNDS-1:0][WORD_W-1:0] keys_o
);
  always_ff @(posedge clk) begin
    if (wr_en) keys_o[wr_idx] <= wr_data;
  end
endmodule

// File: rtl/cipher_pipe.sv
module cipher_pipe
  import cipher_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_decrypt,
  input  logic [BLOCK_W-1:0]   in_block,
  input  logic                 key_wr_en,
  input  logic [KIDX_W-1:0]    key_wr_idx,
  input  logic [WORD_W-1:0]    key_wr_data,
  output logic                 out_valid,
  output logic [BLOCK_W-1:0]   out_block
);
  logic [ROUNDS-1:0][WORD_W-1:0] rk_all;
  logic [ROUNDS:0]               stg_vld;
  logic [ROUNDS:0]               stg_dec;
  block_t                        stg_blk [0:ROUNDS];
  word_t                         stg_rk  [0:ROUNDS-1];

  round_key_bank u_keys (
    .clk     (clk),
    .wr_en   (key_wr_en),
    .wr_idx  (key_wr_idx),
    .wr_data (key_wr_data),
    .keys_o  (rk_all)
  );

  assign stg_vld[0] = in_valid;
  assign stg_dec[0] = in_decrypt;
  assign stg_blk[0] = in_block;

  for (genvar i = 0; i < ROUNDS; i++) begin : g_stage
    assign stg_rk[i] = stg_dec[i] ? rk_all[ROUNDS-1-i] : rk_all[i];
    pipe_stage u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (stg_vld[i]),
      .dec_i (stg_dec[i]),
      .blk_i (stg_blk[i]),
      .rk_i  (stg_rk[i]),
      .vld_o (stg_vld[i+1]),
      .dec_o (stg_dec[i+1]),
      .blk_o (stg_blk[i+1])
    );
  end

  assign out_valid = stg_vld[ROUNDS];
  assign out_block = {stg_blk[ROUNDS][WORD_W-1:0],
                      stg_blk[ROUNDS][2*WORD_W-1:WORD_W],
                      stg_blk[ROUNDS][3*WORD_W-1:2*WORD_W],
                      stg_blk[ROUNDS][4*WORD_W-1:3*WORD_W]};

  // checking state: input valid and mode history, independent of the stage chain
  logic [ROUNDS-1:0] chk_vhist;
  logic [ROUNDS-1:0] chk_dhist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_vhist <= '0;
      chk_dhist <= '0;
    end else begin
      chk_vhist <= {chk_vhist[ROUNDS-2:0], in_valid};
      chk_dhist <= {chk_dhist[ROUNDS-2:0], in_decrypt};
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid); // R1
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == chk_vhist[ROUNDS-1]); // R2
  AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> stg_dec[ROUNDS] == chk_dhist[ROUNDS-1]); // R6
  AST_KEY_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr_en |-> (!in_valid && !(|stg_vld[ROUNDS:1]))); // R7
  AST_KEY_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr_en |=> rk_all[$past(key_wr_idx)] == $past(key_wr_data)); // R7
endmodule

// File: tb/cipher_pipe_tb.sv
module cipher_pipe_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_decrypt = 1'b0;
  logic [127:0] in_block = '0;
  logic         key_wr_en = 1'b0;
  logic [4:0]   key_wr_idx = '0;
  logic [31:0]  key_wr_data = '0;
  logic         out_valid;
  logic [127:0] out_block;

  always #5 clk = ~clk;

  cipher_pipe dut_i (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_decrypt (in_decrypt),
    .in_block (in_block), .key_wr_en (key_wr_en), .key_wr_idx (key_wr_idx),
    .key_wr_data (key_wr_data), .out_valid (out_valid), .out_block (out_block)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  logic [7:0]   sb [256];
  logic [31:0]  cur_rk [32];
  logic [127:0] exp_q [$];
  int           due_q [$];
  string        tag_q [$];

  localparam logic [127:0] KAT_KEY = 128'h0123456789abcdeffedcba9876543210;
  localparam logic [127:0] KAT_CT  = 128'h681edf34d206965e86b3e94f536e4246;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] tb_gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p ^= a;
      a = a[7] ? ({a[6:0], 1'b0} ^ 8'hF5) : {a[6:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [7:0] tb_aff(logic [7:0] x);
    logic [7:0] masks [8] = '{8'hA7, 8'h4F, 8'h9E, 8'h3D, 8'h7A, 8'hF4, 8'hE9, 8'hD3};
    logic [7:0] y;
    for (int i = 0; i < 8; i++) y[i] = ^(x & masks[i]);
    return y ^ 8'hD3;
  endfunction

  function automatic logic [31:0] rol(logic [31:0] w, int n);
    return (w << n) | (w >> (32 - n));
  endfunction

  function automatic logic [31:0] tau(logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic void expand(logic [127:0] mk);
    logic [31:0] k [4];
    logic [31:0] ck, b, nk;
    k[0] = mk[127:96] ^ 32'hA3B1BAC6; k[1] = mk[95:64] ^ 32'h56AA3350;
    k[2] = mk[63:32]  ^ 32'h677D9197; k[3] = mk[31:0]  ^ 32'hB27022DC;
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 4; j++) ck[31-8*j -: 8] = 8'(((4*i + j) * 7) % 256);
      b  = tau(k[1] ^ k[2] ^ k[3] ^ ck);
      nk = k[0] ^ b ^ rol(b, 13) ^ rol(b, 23);
      cur_rk[i] = nk;
      k[0] = k[1]; k[1] = k[2]; k[2] = k[3]; k[3] = nk;
    end
  endfunction

  function automatic logic [127:0] model(logic [127:0] blk, logic dec);
    logic [31:0] x0, x1, x2, x3, b, t;
    {x0, x1, x2, x3} = blk;
    for (int r = 0; r < 32; r++) begin
      b = tau(x1 ^ x2 ^ x3 ^ (dec ? cur_rk[31-r] : cur_rk[r]));
      t = x0 ^ b ^ rol(b, 2) ^ rol(b, 10) ^ rol(b, 18) ^ rol(b, 24);
      x0 = x1; x1 = x2; x2 = x3; x3 = t;
    end
    return {x3, x2, x1, x0};
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic drive(logic v, logic d, logic [127:0] b, string tag, logic [127:0] expv);
    @(negedge clk);
    in_valid = v; in_decrypt = d; in_block = b;
    if (v) begin exp_q.push_back(expv); due_q.push_back(cyc + 32); tag_q.push_back(tag); end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0, "", '0);
  endtask

  task automatic load_keys();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      key_wr_en = 1'b1; key_wr_idx = 5'(i); key_wr_data = cur_rk[i];
    end
    @(negedge clk);
    key_wr_en = 1'b0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // monitor, sampling 3 ns after each rising edge
  always @(posedge clk) begin
    #3;
    if (!done && rst_n) begin
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        check(out_valid, {tag_q[0], " R2 valid"}, {127'd0, out_valid}, 128'd1);
        check(out_block == exp_q[0], tag_q[0], out_block, exp_q[0]);
        void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
      end else begin
        check(!out_valid, "R2 idle", {127'd0, out_valid}, 128'd0);
      end
    end
  end

  logic [127:0] pts [64];
  logic [127:0] cts [64];
  int           npair;

  initial begin
    void'($urandom(32'h5EED1234));
    for (int x = 0; x < 256; x++) begin
      logic [7:0] a, inv;
      a = tb_aff(8'(x));
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (tb_gmul(a, 8'(y)) == 8'h01) inv = 8'(y);
      sb[x] = tb_aff(inv);
    end
    repeat (3) @(negedge clk);
    check(!out_valid, "R1 in reset", {127'd0, out_valid}, 128'd0);
    rst_n = 1'b1;
    idle(2);
    check(!out_valid, "R1 after reset", {127'd0, out_valid}, 128'd0);

    // known answer, both directions (R4, R5, R8, R9)
    expand(KAT_KEY);
    load_keys();
    drive(1'b1, 1'b0, KAT_KEY, "R4 R8 R9 known answer", KAT_CT);
    idle(3);
    drive(1'b1, 1'b1, KAT_CT, "R5 known answer", KAT_KEY);
    idle(40);

    // back-to-back mixed stream, then decrypt of every ciphertext (R3, R6, R5)
    npair = 0;
    for (int n = 0; n < 48; n++) begin
      logic [127:0] pt, ex;
      logic d;
      pt = rnd128(); d = 1'($urandom % 2);
      ex = model(pt, d);
      if (!d) begin pts[npair] = pt; cts[npair] = ex; npair++; end
      drive(1'b1, d, pt, "R3 R6 R8 stream", ex);
    end
    for (int n = 0; n < npair; n++) drive(1'b1, 1'b1, cts[n], "R5 round trip", pts[n]);
    // sparse random valid pattern (R2)
    for (int n = 0; n < 40; n++) begin
      logic [127:0] pt;
      logic d;
      pt = rnd128(); d = 1'($urandom % 2);
      if ($urandom % 3 == 0) drive(1'b1, d, pt, "R2 R6 sparse", model(pt, d));
      else idle(1);
    end
    idle(40);

    // degenerate inputs with all-zero keys (R8)
    for (int i = 0; i < 32; i++) cur_rk[i] = '0;
    load_keys();
    drive(1'b1, 1'b0, '0, "R8 zero keys zero block", model('0, 1'b0));
    drive(1'b1, 1'b0, '1, "R8 zero keys ones block", model('1, 1'b0));
    drive(1'b1, 1'b1, '1, "R8 zero keys ones decrypt", model('1, 1'b1));
    idle(40);

    // full reload, then single-word rewrite (R7)
    expand(rnd128());
    load_keys();
    for (int n = 0; n < 16; n++) begin
      logic [127:0] pt;
      logic d;
      pt = rnd128(); d = 1'(n % 2);
      drive(1'b1, d, pt, "R7 reloaded keys", model(pt, d));
    end
    idle(40);
    @(negedge clk);
    cur_rk[31] = $urandom;
    key_wr_en = 1'b1; key_wr_idx = 5'd31; key_wr_data = cur_rk[31];
    @(negedge clk);
    key_wr_en = 1'b0;
    begin
      logic [127:0] pt;
      pt = rnd128();
      drive(1'b1, 1'b0, pt, "R7 key 31 rewrite enc", model(pt, 1'b0));
      drive(1'b1, 1'b1, pt, "R7 key 31 rewrite dec", model(pt, 1'b1));
    end
    idle(40);

    // reset with blocks in flight (R1)
    for (int n = 0; n < 8; n++) begin
      logic [127:0] pt;
      pt = rnd128();
      drive(1'b1, 1'b0, pt, "R1 dropped", model(pt, 1'b0));
    end
    idle(3);
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete(); due_q.delete(); tag_q.delete();
    repeat (2) @(negedge clk);
    check(!out_valid, "R1 mid-stream reset", {127'd0, out_valid}, 128'd0);
    rst_n = 1'b1;
    idle(40);
    begin
      logic [127:0] pt;
      pt = rnd128();
      drive(1'b1, 1'b1, pt, "R1 R7 keys kept", model(pt, 1'b1));
    end
    idle(40);

    check(exp_q.size() == 0, "R2 all results seen", 128'(exp_q.size()), 128'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule